// File: doc/BRIEF.md
# Self-Deteriorating Accuracy Interval Pair

This block keeps the two bounds of an accuracy interval that surrounds a local clock value: a lower-side accuracy and an upper-side accuracy, each 16 bits in whole units. Each bound sits in its own 32-bit accumulator: 16 integer bits on top and 16 fraction bits below. On every oscillator tick a programmable per-tick drift increment is added to the accumulator, so the interval widens on its own by the worst-case oscillator drift between two synchronizations.

Software re-seeds both bounds with one load strobe, in the same cycle that the clock value itself is loaded. While the clock is being slewed gradually, an amortize-enable input subtracts a separate per-tick decrement from each bound. The arithmetic never wraps. Growth stops at all-ones, and a result that would go below zero becomes zero. An event strobe copies both current integer bounds into a pair of snapshot registers, so that they can be stored next to a timestamp taken at the same instant.

Top module: `accuracy_pair`

## Requirements
- R1: During reset and after its release, both accuracy outputs and both snapshot outputs read zero.
- R2: On a cycle with `tick` high and `load` low, each 32-bit accumulator gains its 16-bit drift increment. The increment is in units of 2^-16 of the integer LSB. The output is the upper 16 bits, so a drift of 0x8000 raises the output by 1 every two ticks.
- R3: On a cycle with `tick` and `load` both low, neither accumulator changes, whatever the values of `amort_en`, the drift inputs and the decrement inputs.
- R4: If an addition would exceed 0xFFFF_FFFF, the accumulator saturates at 0xFFFF_FFFF and never wraps. The output then stays at 0xFFFF.
- R5: On a tick while `amort_en` is high, the lane's decrement is also subtracted. The decrement uses the same fractional units as the drift. The net change is drift minus decrement.
- R6: If a tick with amortization would make an accumulator negative, the accumulator becomes exactly zero.
- R7: A `load` writes `load_neg` and `load_pos` into the integer parts of both accumulators in the same cycle and clears both fraction parts. A load takes priority over a tick in the same cycle.
- R8: On an `evt` cycle, both snapshot outputs take the integer accuracy values that were present in that cycle, before any load or tick of that same cycle. Without `evt`, the snapshots hold their values.
- R9: The two lanes are independent. Each lane uses only its own drift, decrement and load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Per-tick advance enable |
| load | input | 1 | Atomic reload of both bounds |
| load_neg | input | 16 | Reload value, lower-side accuracy |
| load_pos | input | 16 | Reload value, upper-side accuracy |
| drift_neg | input | 16 | Per-tick fractional increment, lower side |
| drift_pos | input | 16 | Per-tick fractional increment, upper side |
| amort_en | input | 1 | Apply the amortization decrement on ticks |
| dec_neg | input | 16 | Per-tick fractional decrement, lower side |
| dec_pos | input | 16 | Per-tick fractional decrement, upper side |
| evt | input | 1 | Snapshot strobe |
| acc_neg | output | 16 | Integer lower-side accuracy |
| acc_pos | output | 16 | Integer upper-side accuracy |
| snap_neg | output | 16 | Captured lower-side accuracy |
| snap_pos | output | 16 | Captured upper-side accuracy |

## Verification
The assertions check these rules on every cycle:
- Each bound holds when no tick or load occurs.
- A load lands exactly.
- A tick moves an output by at most one unit.
- Pure growth never makes an output smaller, so a wrap would show up at once.
- Amortization whose decrement is at least the drift never raises an output.
- The snapshots follow the event strobe.

Exact fractional accumulation, the point where saturation takes hold, the exact clamp to zero, and the rule that a load beats a tick can only be shown by the bench's directed scenarios and by its long random run. That run compares every cycle against a 32-bit reference model.

// File: rtl/accuracy_pair.sv
module accuracy_pair #(
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 16,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [ACC_W-1:0]  load_neg,
  input  logic [ACC_W-1:0]  load_pos,
  input  logic [RATE_W-1:0] drift_neg,
  input  logic [RATE_W-1:0] drift_pos,
  input  logic              amort_en,
  input  logic [RATE_W-1:0] dec_neg,
  input  logic [RATE_W-1:0] dec_pos,
  input  logic              evt,
  output logic [ACC_W-1:0]  acc_neg,
  output logic [ACC_W-1:0]  acc_pos,
  output logic [ACC_W-1:0]  snap_neg,
  output logic [ACC_W-1:0]  snap_pos
);
  localparam int TOT_W = ACC_W + FRAC_W;
  localparam int EXT_W = TOT_W + 2;

  logic [ACC_W-1:0]  ld_v  [2];
  logic [RATE_W-1:0] inc_v [2];
  logic [RATE_W-1:0] sub_v [2];

  assign ld_v[0]  = load_neg;
  assign ld_v[1]  = load_pos;
  assign inc_v[0] = drift_neg;
  assign inc_v[1] = drift_pos;
  assign sub_v[0] = dec_neg;
  assign sub_v[1] = dec_pos;

  for (genvar g = 0; g < 2; g++) begin : lane
    logic [TOT_W-1:0]        acc_q;
    logic [ACC_W-1:0]        snap_q;
    logic signed [EXT_W-1:0] sum;
    logic [TOT_W-1:0]        nxt;

    assign sum = $signed({2'b00, acc_q})
               + $signed({{(EXT_W-RATE_W){1'b0}}, inc_v[g]})
               - $signed(amort_en ? {{(EXT_W-RATE_W){1'b0}}, sub_v[g]} : {EXT_W{1'b0}});

    assign nxt = sum[EXT_W-1] ? '0 :
                 sum[TOT_W]   ? '1 : sum[TOT_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q  <= '0;
        snap_q <= '0;
      end else begin
        if (load)      acc_q <= {ld_v[g], {FRAC_W{1'b0}}};
        else if (tick) acc_q <= nxt;
        if (evt)       snap_q <= acc_q[TOT_W-1 -: ACC_W];
      end
    end
  end

  assign acc_neg  = lane[0].acc_q[TOT_W-1 -: ACC_W];
  assign acc_pos  = lane[1].acc_q[TOT_W-1 -: ACC_W];
  assign snap_neg = lane[0].snap_q;
  assign snap_pos = lane[1].snap_q;
endmodule

// File: rtl/accuracy_pair_chk.sv
module accuracy_pair_chk #(
  parameter int ACC_W  = 16,
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              load,
  input logic [ACC_W-1:0]  load_neg,
  input logic [ACC_W-1:0]  load_pos,
  input logic [RATE_W-1:0] drift_neg,
  input logic [RATE_W-1:0] drift_pos,
  input logic              amort_en,
  input logic [RATE_W-1:0] dec_neg,
  input logic [RATE_W-1:0] dec_pos,
  input logic              evt,
  input logic [ACC_W-1:0]  acc_neg,
  input logic [ACC_W-1:0]  acc_pos,
  input logic [ACC_W-1:0]  snap_neg,
  input logic [ACC_W-1:0]  snap_pos
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(acc_neg) && $stable(acc_pos)));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_neg == $past(load_neg) && acc_pos == $past(load_pos)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> ({1'b0, acc_neg} <= {1'b0, $past(acc_neg)} + 17'd1 &&
                         {1'b0, acc_pos} <= {1'b0, $past(acc_pos)} + 17'd1));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !amort_en) |=> (acc_neg >= $past(acc_neg) && acc_pos >= $past(acc_pos)));

  assert_amort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && amort_en && dec_neg >= drift_neg) |=> (acc_neg <= $past(acc_neg)));

  assert_snap_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (snap_neg == $past(acc_neg) && snap_pos == $past(acc_pos)));

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(snap_neg) && $stable(snap_pos)));
endmodule

bind accuracy_pair accuracy_pair_chk #(.ACC_W(ACC_W), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/accuracy_pair_test.sv
module accuracy_pair_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, load = 1'b0, amort_en = 1'b0, evt = 1'b0;
  logic [15:0] load_neg = '0, load_pos = '0, drift_neg = '0, drift_pos = '0;
  logic [15:0] dec_neg = '0, dec_pos = '0;
  logic [15:0] acc_neg, acc_pos, snap_neg, snap_pos;

  accuracy_pair uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_neg = '0, m_pos = '0;
  logic [15:0] s_neg = '0, s_pos = '0;

  function automatic logic [31:0] model_next(logic [31:0] a, logic [15:0] d, logic [15:0] c, logic en);
    longint t;
    t = longint'(a) + longint'(d) - (en ? longint'(c) : 64'sd0);
    if (t < 0) return 32'h0;
    if (t > 64'sh0_FFFF_FFFF) return 32'hFFFF_FFFF;
    return t[31:0];
  endfunction

  task automatic chk(string r, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_neg = '0; m_pos = '0; s_neg = '0; s_pos = '0;
    end else begin
      if (evt) begin s_neg = m_neg[31:16]; s_pos = m_pos[31:16]; end
      if (load) begin
        m_neg = {load_neg, 16'h0}; m_pos = {load_pos, 16'h0};
      end else if (tick) begin
        m_neg = model_next(m_neg, drift_neg, dec_neg, amort_en);
        m_pos = model_next(m_pos, drift_pos, dec_pos, amort_en);
      end
    end
    @(negedge clk);
  endtask

  task automatic check_model(string r);
    chk(r, acc_neg, m_neg[31:16]);
    chk(r, acc_pos, m_pos[31:16]);
    chk(r, snap_neg, s_neg);
    chk(r, snap_pos, s_pos);
  endtask

  task automatic idle();
    tick = 0; load = 0; amort_en = 0; evt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) step();
    chk("R1 reset acc_neg", acc_neg, 16'h0);
    chk("R1 reset snap_pos", snap_pos, 16'h0);
    rst_n = 1;
    step();
    chk("R1 after release acc_pos", acc_pos, 16'h0);

    // R2 / R9: fractional growth, independent rates
    drift_neg = 16'h8000; drift_pos = 16'h4000; tick = 1;
    repeat (4) step();
    chk("R2 half-unit drift", acc_neg, 16'd2);
    chk("R9 quarter-unit drift", acc_pos, 16'd1);

    // R3: no tick, amortization asserted, nothing moves
    tick = 0; amort_en = 1; dec_neg = 16'hFFFF; dec_pos = 16'hFFFF;
    repeat (5) step();
    chk("R3 hold neg", acc_neg, 16'd2);
    chk("R3 hold pos", acc_pos, 16'd1);
    idle();

    // R4: saturation
    load = 1; load_neg = 16'hFFFE; load_pos = 16'h0010; step(); load = 0;
    chk("R7 load neg", acc_neg, 16'hFFFE);
    drift_neg = 16'hFFFF; drift_pos = 16'h0; tick = 1;
    step(); chk("R4 before limit", acc_neg, 16'hFFFE);
    step(); chk("R4 reach top", acc_neg, 16'hFFFF);
    repeat (6) step();
    chk("R4 saturated no wrap", acc_neg, 16'hFFFF);
    chk("R9 other lane untouched", acc_pos, 16'h0010);
    idle();

    // R6: clamp to zero
    load = 1; load_neg = 16'd1; load_pos = 16'd3; step(); load = 0;
    drift_neg = 0; dec_neg = 16'hFFFF; drift_pos = 0; dec_pos = 0;
    tick = 1; amort_en = 1;
    repeat (3) step();
    amort_en = 0; drift_neg = 16'h0001;
    repeat (4) step();
    chk("R6 clamped to zero", acc_neg, 16'h0);
    chk("R6 lane without decrement", acc_pos, 16'd3);
    idle();

    // R5: net drift minus decrement
    load = 1; load_neg = 16'd10; load_pos = 16'd10; step(); load = 0;
    drift_neg = 16'h1000; dec_neg = 16'h9000; drift_pos = 16'h1000; dec_pos = 16'h1000;
    tick = 1; amort_en = 1;
    repeat (4) step();
    chk("R5 net decrease", acc_neg, 16'd8);
    chk("R5 balanced", acc_pos, 16'd10);
    idle();

    // R7: load beats tick; R8: snapshot takes pre-load value
    tick = 1; load = 1; evt = 1; drift_neg = 16'hFFFF; drift_pos = 16'hFFFF; amort_en = 0;
    load_neg = 16'd5; load_pos = 16'd6;
    step();
    chk("R7 load wins neg", acc_neg, 16'd5);
    chk("R7 load wins pos", acc_pos, 16'd6);
    chk("R8 snapshot pre-load neg", snap_neg, 16'd8);
    chk("R8 snapshot pre-load pos", snap_pos, 16'd10);
    idle();
    repeat (3) step();
    chk("R8 snapshot held", snap_neg, 16'd8);
    check_model("R1 R7 R8 model sync");

    // random mix against the model
    for (int i = 0; i < 5000; i++) begin
      tick     = ($urandom_range(99) < 75);
      load     = ($urandom_range(99) < 3);
      amort_en = ($urandom_range(99) < 40);
      evt      = ($urandom_range(99) < 10);
      drift_neg = 16'($urandom); drift_pos = 16'($urandom);
      dec_neg   = 16'($urandom); dec_pos   = 16'($urandom);
      case ($urandom_range(3))
        0: begin load_neg = 16'hFFFF - 16'($urandom_range(3)); load_pos = 16'($urandom_range(3)); end
        1: begin load_neg = 16'($urandom_range(3)); load_pos = 16'hFFFF - 16'($urandom_range(3)); end
        default: begin load_neg = 16'($urandom); load_pos = 16'($urandom); end
      endcase
      step();
      check_model("R2 R4 R5 R6 R7 R8 R9 random");
    end
    idle();
    finish_run();
  end
endmodule